// File: doc/BRIEF.md
# Three-Word Instruction Fetch Sequencer

This block fetches fixed-length 48-bit instructions from a memory that is only 16 bits wide and addressed by 19 bits. Each instruction takes three reads from consecutive addresses. The block keeps an instruction pointer and a memory address register. It places each returned word into the correct slice of an instruction register. After the third word is in, it presents the decoded fields for one cycle: a 5-bit opcode, a 3-bit addressing mode and two 19-bit operand addresses.

When the decoded mode is indirect, the block goes on to fetch the pointer word. It reads memory at the first operand address. The returned 16-bit word replaces only the low 16 bits of the address register, and the top three bits of the register are kept. The block then shows the resulting effective address for one cycle before it resumes fetching at the instruction pointer.

The memory side uses a simple handshake. A read is accepted at a rising edge where `mem_req_o` and `mem_rdy_i` are both high. In that cycle `mem_rdata_i` must carry the word stored at `mem_addr_o`. All state is held in registers clocked on the rising edge, and the reset is synchronous.

Top module: `ifetch_seq`

## Requirements
- R1: After a synchronous reset the instruction pointer and the address output are 0. A request is pending for the first word, and neither valid pulse is high.
- R2: An instruction is fetched as three accepted reads at addresses ip, ip+1 and ip+2, in that order. The address output steps by one after each of the first two accepted words.
- R3: While `mem_rdy_i` is low the address output, the instruction pointer and the fetch position hold, and no valid pulse is raised.
- R4: `instr_vld_o` is high for exactly one cycle, the cycle after the third word is accepted. The first word read fills instruction bits 47:32, the second fills 31:16 and the third fills 15:0.
- R5: While `instr_vld_o` is high the outputs carry the opcode from bits 47:43, the mode from bits 42:40, operand 1 from bits 37:19 and operand 2 from bits 18:0. Bits 39:38 have no effect on any output.
- R6: The instruction pointer advances by 3 (modulo 2^19) on the same edge that accepts the third word.
- R7: Mode code 2 means indirect. After the valid pulse, the next read is at operand 1. The word returned by that read replaces address bits 15:0, and bits 18:16 stay equal to operand 1's bits 18:16. The result appears on `mem_addr_o` for one cycle with `ptr_vld_o` high and `mem_req_o` low. Fetching then resumes at the instruction pointer.
- R8: The other mode codes (0 immediate, 1 direct, 3 register direct, 4 register indirect, 5 index, 6 displacement, 7 unassigned) cause no pointer read. The next read after the valid pulse is the first word of the next instruction, at the updated pointer.
- R9: A reset asserted in the middle of an instruction abandons it. Fetching restarts at address 0 with the first word slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mem_req_o | output | 1 | Read request toward memory |
| mem_addr_o | output | 19 | Memory address register contents |
| mem_rdata_i | input | 16 | Word read from memory |
| mem_rdy_i | input | 1 | Memory accepts the read this cycle |
| ip_o | output | 19 | Instruction pointer |
| instr_vld_o | output | 1 | One-cycle pulse: decoded fields are valid |
| opcode_o | output | 5 | Opcode field |
| amode_o | output | 3 | Addressing-mode field |
| opnd1_o | output | 19 | First operand address |
| opnd2_o | output | 19 | Second operand address |
| ptr_vld_o | output | 1 | One-cycle pulse: mem_addr_o holds the indirect effective address |

## Verification
The fetch path is first tried with memory always ready and then with a pseudo-random ready pattern. The ready-always run shows the bare three-read timing. The random run separates correct stalling from words that are captured twice or skipped. The instruction contents use all-ones and all-zeros operands, set padding bits, and a mode from each class. Together these expose swapped slices, shifted field boundaries, padding that leaks into an operand, and a direct mode mistaken for indirect. The indirect targets have distinct upper three bits, so a merge that drops or overwrites those bits shows up. A long forced stall and a reset between words exercise the holding and restart behaviour.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_PTR   = 2'd1,
        ST_EA    = 2'd2
    } fetch_st_e;

endpackage

// File: rtl/ifu_slot_insert.sv
module ifu_slot_insert #(
    parameter int WORD_W = 16,
    parameter int WORDS  = 3,
    parameter int SLOT_W = 2,
    localparam int INSTR_W = WORD_W * WORDS
) (
    input  logic [INSTR_W-1:0] ir_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic [SLOT_W-1:0]  slot_i,
    input  logic               en_i,
    output logic [INSTR_W-1:0] ir_o
);

    // Slot 0 is the most significant word of the instruction.
    for (genvar k = 0; k < WORDS; k++) begin : g_slot
        localparam int HI = (WORDS - k) * WORD_W - 1;
        assign ir_o[HI -: WORD_W] = (en_i && (slot_i == SLOT_W'(k))) ? word_i
                                                                     : ir_i[HI -: WORD_W];
    end

endmodule

// File: rtl/ifu_field_split.sv
module ifu_field_split #(
    parameter int INSTR_W = 48,
    parameter int ADDR_W  = 19,
    parameter int OPC_W   = 5,
    parameter int MODE_W  = 3
) (
    input  logic [INSTR_W-1:0] ir_i,
    output logic [OPC_W-1:0]   opc_o,
    output logic [MODE_W-1:0]  mode_o,
    output logic [ADDR_W-1:0]  op1_o,
    output logic [ADDR_W-1:0]  op2_o
);

    localparam int OPC_LO  = INSTR_W - OPC_W;
    localparam int MODE_LO = OPC_LO - MODE_W;
    localparam int OP1_LO  = ADDR_W;
    localparam int PAD_W   = MODE_LO - 2 * ADDR_W;

    assign opc_o  = ir_i[INSTR_W-1 -: OPC_W];
    assign mode_o = ir_i[OPC_LO-1 -: MODE_W];
    assign op1_o  = ir_i[OP1_LO +: ADDR_W];
    assign op2_o  = ir_i[ADDR_W-1:0];

    if (PAD_W > 0) begin : g_pad
        logic unused_pad;
        assign unused_pad = ^ir_i[MODE_LO-1 -: PAD_W];
    end

endmodule

// File: rtl/ifu_ptr_merge.sv
module ifu_ptr_merge #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 19
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [WORD_W-1:0] word_i,
    output logic [ADDR_W-1:0] addr_o
);

    if (ADDR_W > WORD_W) begin : g_keep_top
        logic unused_low;
        assign unused_low = ^base_i[WORD_W-1:0];
        assign addr_o     = {base_i[ADDR_W-1:WORD_W], word_i};
    end else begin : g_word_only
        logic unused_all;
        assign unused_all = ^{base_i, word_i};
        assign addr_o     = word_i[ADDR_W-1:0];
    end

endmodule

// File: rtl/ifetch_seq.sv
module ifetch_seq
    import ifu_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = 19,
    parameter int WORDS    = 3,
    parameter int OPC_W    = 5,
    parameter int MODE_W   = 3,
    parameter int IND_MODE = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_rdy_i,
    output logic [ADDR_W-1:0] ip_o,
    output logic              instr_vld_o,
    output logic [OPC_W-1:0]  opcode_o,
    output logic [MODE_W-1:0] amode_o,
    output logic [ADDR_W-1:0] opnd1_o,
    output logic [ADDR_W-1:0] opnd2_o,
    output logic              ptr_vld_o
);

    localparam int INSTR_W = WORD_W * WORDS;
    localparam int CNT_W   = (WORDS > 1) ? $clog2(WORDS) : 1;

    typedef struct packed {
        fetch_st_e          st;
        logic [CNT_W-1:0]   wcnt;
        logic [ADDR_W-1:0]  ip;
        logic [ADDR_W-1:0]  mar;
        logic [INSTR_W-1:0] ir;
        logic               vld;
    } regs_t;

    regs_t cur_q, nxt_d;

    logic [INSTR_W-1:0] ir_ins;
    logic [ADDR_W-1:0]  ptr_addr;
    logic [ADDR_W-1:0]  ip_step;
    logic               in_fetch;
    logic               word_last;

    assign in_fetch  = (cur_q.st == ST_FETCH);
    assign word_last = (cur_q.wcnt == CNT_W'(WORDS - 1));
    assign ip_step   = cur_q.ip + ADDR_W'(WORDS);

    ifu_slot_insert #(
        .WORD_W (WORD_W),
        .WORDS  (WORDS),
        .SLOT_W (CNT_W)
    ) u_insert (
        .ir_i   (cur_q.ir),
        .word_i (mem_rdata_i),
        .slot_i (cur_q.wcnt),
        .en_i   (in_fetch & mem_rdy_i),
        .ir_o   (ir_ins)
    );

    // Mode and operand 1 sit in the earlier words, so on the last word
    // they are already decodable from the held register.
    ifu_field_split #(
        .INSTR_W (INSTR_W),
        .ADDR_W  (ADDR_W),
        .OPC_W   (OPC_W),
        .MODE_W  (MODE_W)
    ) u_split (
        .ir_i   (cur_q.ir),
        .opc_o  (opcode_o),
        .mode_o (amode_o),
        .op1_o  (opnd1_o),
        .op2_o  (opnd2_o)
    );

    ifu_ptr_merge #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W)
    ) u_merge (
        .base_i (cur_q.mar),
        .word_i (mem_rdata_i),
        .addr_o (ptr_addr)
    );

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        unique case (cur_q.st)
            ST_FETCH: begin
                if (mem_rdy_i) begin
                    nxt_d.ir = ir_ins;
                    if (word_last) begin
                        nxt_d.wcnt = '0;
                        nxt_d.vld  = 1'b1;
                        nxt_d.ip   = ip_step;
                        if (amode_o == MODE_W'(IND_MODE)) begin
                            nxt_d.mar = opnd1_o;
                            nxt_d.st  = ST_PTR;
                        end else begin
                            nxt_d.mar = ip_step;
                        end
                    end else begin
                        nxt_d.wcnt = cur_q.wcnt + CNT_W'(1);
                        nxt_d.mar  = cur_q.mar + ADDR_W'(1);
                    end
                end
            end
            ST_PTR: begin
                if (mem_rdy_i) begin
                    nxt_d.mar = ptr_addr;
                    nxt_d.st  = ST_EA;
                end
            end
            ST_EA: begin
                nxt_d.mar = cur_q.ip;
                nxt_d.st  = ST_FETCH;
            end
            default: begin
                nxt_d.st = ST_FETCH;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cur_q <= '{st: ST_FETCH, wcnt: '0, ip: '0, mar: '0, ir: '0, vld: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_req_o   = in_fetch | (cur_q.st == ST_PTR);
    assign mem_addr_o  = cur_q.mar;
    assign ip_o        = cur_q.ip;
    assign instr_vld_o = cur_q.vld;
    assign ptr_vld_o   = (cur_q.st == ST_EA);

endmodule

// File: rtl/ifu_chk.sv
module ifu_chk #(
    parameter int WORD_W   = 16,
    parameter int ADDR_W   = 19,
    parameter int WORDS    = 3,
    parameter int MODE_W   = 3,
    parameter int IND_MODE = 2
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              mem_req_i,
    input logic              mem_rdy_i,
    input logic [ADDR_W-1:0] mem_addr_i,
    input logic [WORD_W-1:0] mem_rdata_i,
    input logic [ADDR_W-1:0] ip_i,
    input logic              vld_i,
    input logic              ptr_vld_i,
    input logic [MODE_W-1:0] amode_i,
    input logic [ADDR_W-1:0] opnd1_i,
    input logic              in_fetch_i,
    input logic              word_last_i
);

    a_r3_stall_hold: assert property (@(posedge clk_i) disable iff (rst_i)
        (mem_req_i && !mem_rdy_i) |=> ($stable(mem_addr_i) && $stable(ip_i) && !vld_i && !ptr_vld_i));

    a_r2_word_step: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_fetch_i && mem_rdy_i && !word_last_i) |=> (mem_addr_i == $past(mem_addr_i) + ADDR_W'(1)));

    a_r4_valid_single: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_i |=> !vld_i);

    a_r6_ip_step: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_i |-> (ip_i == $past(ip_i) + ADDR_W'(WORDS)));

    a_r7_ptr_merge: assert property (@(posedge clk_i) disable iff (rst_i)
        ptr_vld_i |-> (!mem_req_i
                       && mem_addr_i[ADDR_W-1:WORD_W] == opnd1_i[ADDR_W-1:WORD_W]
                       && mem_addr_i[WORD_W-1:0] == $past(mem_rdata_i)));

    a_r7_ind_target: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && amode_i == MODE_W'(IND_MODE)) |-> (!in_fetch_i && mem_addr_i == opnd1_i));

    a_r8_direct_next: assert property (@(posedge clk_i) disable iff (rst_i)
        (vld_i && amode_i != MODE_W'(IND_MODE)) |-> (in_fetch_i && mem_addr_i == ip_i));

endmodule

bind ifetch_seq ifu_chk #(
    .WORD_W   (WORD_W),
    .ADDR_W   (ADDR_W),
    .WORDS    (WORDS),
    .MODE_W   (MODE_W),
    .IND_MODE (IND_MODE)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .mem_req_i   (mem_req_o),
    .mem_rdy_i   (mem_rdy_i),
    .mem_addr_i  (mem_addr_o),
    .mem_rdata_i (mem_rdata_i),
    .ip_i        (ip_o),
    .vld_i       (instr_vld_o),
    .ptr_vld_i   (ptr_vld_o),
    .amode_i     (amode_o),
    .opnd1_i     (opnd1_o),
    .in_fetch_i  (in_fetch),
    .word_last_i (word_last)
);

// File: tb/ifetch_seq_tb.sv
module ifetch_seq_tb;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int AW = 19;
    localparam int WW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rdy = 1'b0;
    logic [WW-1:0] rdata;
    logic          req;
    logic [AW-1:0] addr;
    logic [AW-1:0] ip;
    logic          vld;
    logic [4:0]    opc;
    logic [2:0]    amode;
    logic [AW-1:0] op1;
    logic [AW-1:0] op2;
    logic          pvld;

    always #2.5 clk = ~clk;

    ifetch_seq u_dut (
        .clk_i       (clk),
        .rst_i       (rst),
        .mem_req_o   (req),
        .mem_addr_o  (addr),
        .mem_rdata_i (rdata),
        .mem_rdy_i   (rdy),
        .ip_o        (ip),
        .instr_vld_o (vld),
        .opcode_o    (opc),
        .amode_o     (amode),
        .opnd1_o     (op1),
        .opnd2_o     (op2),
        .ptr_vld_o   (pvld)
    );

    // Memory model: small program area, address-derived words elsewhere.
    logic [WW-1:0] prog [0:63];
    assign rdata = (addr < AW'(64)) ? prog[addr[5:0]] : (addr[15:0] ^ 16'hA5C3);

    function automatic logic [WW-1:0] model_word(logic [AW-1:0] a);
        if (a < AW'(64)) return prog[a[5:0]];
        return a[15:0] ^ 16'hA5C3;
    endfunction

    // Ready pattern: 0 never, 1 always, 2 pseudo-random.
    int         rdy_mode = 0;
    logic [7:0] lfsr = 8'hB5;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        case (rdy_mode)
            1:       rdy = 1'b1;
            2:       rdy = lfsr[0] | lfsr[3];
            default: rdy = 1'b0;
        endcase
    end

    typedef struct {
        logic [4:0]    opc;
        logic [2:0]    mode;
        logic [AW-1:0] op1;
        logic [AW-1:0] op2;
        logic [AW-1:0] ip;
    } item_t;

    item_t         exp_q[$];
    logic [AW-1:0] addr_q[$];
    logic [AW-1:0] ptr_q[$];
    int            n_chk = 0;
    int            n_fail = 0;
    bit            scoring = 1'b0;
    bit            prev_vld = 1'b0;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Driver: place an instruction at slot k and push what it must produce.
    task automatic put_instr(int k, logic [4:0] o, logic [2:0] m,
                             logic [AW-1:0] a1, logic [AW-1:0] a2, logic [1:0] pad);
        logic [47:0] w;
        item_t       it;
        w = {o, m, pad, a1, a2};
        prog[3*k]     = w[47:32];
        prog[3*k + 1] = w[31:16];
        prog[3*k + 2] = w[15:0];
        it.opc  = o;
        it.mode = m;
        it.op1  = a1;
        it.op2  = a2;
        it.ip   = AW'(3 * (k + 1));
        exp_q.push_back(it);
        addr_q.push_back(AW'(3 * k));
        addr_q.push_back(AW'(3 * k + 1));
        addr_q.push_back(AW'(3 * k + 2));
        if (m == 3'd2) begin
            addr_q.push_back(a1);
            ptr_q.push_back({a1[18:16], model_word(a1)});
        end
    endtask

    // Monitor: compare at the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (!rst && scoring) begin
            if (req && rdy && addr_q.size() > 0) begin
                logic [AW-1:0] ea;
                ea = addr_q.pop_front();
                chk("R2 R7 R8 read address order", addr, ea);
            end
            if (vld) begin
                chk("R4 valid lasts one cycle", prev_vld, 1'b0);
                if (exp_q.size() > 0) begin
                    item_t it;
                    it = exp_q.pop_front();
                    chk("R4 R5 opcode", opc, it.opc);
                    chk("R5 mode", amode, it.mode);
                    chk("R5 operand1", op1, it.op1);
                    chk("R5 operand2", op2, it.op2);
                    chk("R6 pointer advance", ip, it.ip);
                end
            end
            if (pvld && ptr_q.size() > 0) begin
                logic [AW-1:0] pa;
                pa = ptr_q.pop_front();
                chk("R7 merged effective address", addr, pa);
                chk("R7 no request with result", req, 1'b0);
            end
        end
        prev_vld = vld;
    end

    task automatic clear_prog();
        for (int i = 0; i < 64; i++) prog[i] = 16'h0000;
    endtask

    task automatic do_reset();
        scoring  = 1'b0;
        rdy_mode = 0;
        @(posedge clk);
        #1 rst = 1'b1;
        exp_q.delete();
        addr_q.delete();
        ptr_q.delete();
        clear_prog();
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wait_drain(string tag);
        int n = 0;
        while ((exp_q.size() > 0 || addr_q.size() > 0 || ptr_q.size() > 0) && n < 5000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " drained before timeout"}, (n < 5000), 1'b1);
    endtask

    always begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        clear_prog();
        do_reset();

        // R1: state straight after reset
        @(negedge clk);
        chk("R1 ip after reset", ip, 0);
        chk("R1 address after reset", addr, 0);
        chk("R1 request pending", req, 1'b1);
        chk("R1 no instruction valid", vld, 1'b0);
        chk("R1 no pointer valid", pvld, 1'b0);

        // Phase A: always ready, field extremes, padding set
        put_instr(0, 5'h11, 3'd1, 19'h12345, 19'h70F0F, 2'b11);
        put_instr(1, 5'h1F, 3'd0, 19'h7FFFF, 19'h00000, 2'b00);
        put_instr(2, 5'h00, 3'd5, 19'h00000, 19'h7FFFF, 2'b10);
        put_instr(3, 5'h0A, 3'd2, 19'h60ABC, 19'h05555, 2'b01);
        put_instr(4, 5'h07, 3'd3, 19'h2AAAA, 19'h15555, 2'b11);
        scoring  = 1'b1;
        rdy_mode = 1;
        wait_drain("R2 phase always-ready");

        // Phase B: random ready, two indirect targets with different top bits
        do_reset();
        put_instr(0, 5'h03, 3'd2, 19'h58001, 19'h00011, 2'b00);
        put_instr(1, 5'h15, 3'd6, 19'h2AAAA, 19'h12121, 2'b11);
        put_instr(2, 5'h1C, 3'd2, 19'h7FFF0, 19'h3C3C3, 2'b10);
        put_instr(3, 5'h09, 3'd7, 19'h0F0F0, 19'h70707, 2'b01);
        put_instr(4, 5'h12, 3'd4, 19'h11111, 19'h66666, 2'b00);
        scoring  = 1'b1;
        rdy_mode = 2;
        wait_drain("R3 R7 phase random-ready");

        // Phase C: R3 long stall before the first word
        do_reset();
        put_instr(0, 5'h0E, 3'd1, 19'h33333, 19'h44444, 2'b00);
        scoring = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk("R3 address held in stall", addr, 0);
            chk("R3 no valid in stall", vld, 1'b0);
        end
        rdy_mode = 1;
        wait_drain("R3 phase after stall");

        // Phase D: R9 reset between words
        do_reset();
        put_instr(0, 5'h1B, 3'd1, 19'h40404, 19'h50505, 2'b00);
        put_instr(1, 5'h06, 3'd0, 19'h01010, 19'h02020, 2'b00);
        rdy_mode = 1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 fetch has moved past word 0", (addr != 0), 1'b1);
        @(posedge clk);
        #1 rst = 1'b1;
        rdy_mode = 0;
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk("R9 address restarts at 0", addr, 0);
        chk("R9 ip restarts at 0", ip, 0);
        chk("R9 request pending after restart", req, 1'b1);
        exp_q.delete();
        addr_q.delete();
        ptr_q.delete();
        put_instr(0, 5'h1B, 3'd1, 19'h40404, 19'h50505, 2'b00);
        put_instr(1, 5'h06, 3'd0, 19'h01010, 19'h02020, 2'b00);
        scoring  = 1'b1;
        rdy_mode = 1;
        wait_drain("R9 phase restart");

        scoring  = 1'b0;
        rdy_mode = 0;
        repeat (2) @(posedge clk);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule